// File: doc/BRIEF.md
# Object Field Cache

This block is a small data cache for heap objects. A request names an object by its reference and picks one field of that object by index, with no byte address involved. Each cache line belongs to one object. The line's tag is the object reference, and each field of the line has its own valid bit. All line tags are compared against the incoming reference at the same time. The field index selects one valid bit in every line during that same compare. The line that matches is then encoded to a line number, and the line number followed by the field index addresses the data store.

Reads that find the field resident return it one cycle after acceptance, with no memory traffic. A read whose object is not resident claims a line in round-robin order, empties it, and fetches only the requested field over a simple request/acknowledge memory port. A read whose object is resident but whose field is not fetches that field into the existing line. Writes always go through to memory. If the object is resident, a write also updates the line. A field index past the line's field count is passed straight to memory. An invalidate input empties every field in a single cycle.

Top module: `ofc_cache`

## Requirements
- R1: After reset, req_ready is 1, rsp_valid is 0, mem_req is 0, and no field is resident, so the first read of any field goes to memory.
- R2: A read whose reference matches a line tag, and whose field valid bit in that line is set, raises rsp_valid with rsp_hit = 1 and the stored data exactly one cycle after acceptance. It raises no memory request.
- R3: A read whose reference matches no line tag claims the next line in round-robin order (line 0, then 1, and so on, wrapping). The line gets the new tag and all its field valid bits are cleared. Exactly one memory read is issued, for the requested field only. rsp_valid follows on the cycle after mem_ack, with rsp_hit = 0 and the memory data. With single-cycle memory this is 3 cycles after acceptance.
- R4: A read whose reference matches a tag but whose field is not valid fetches that field into the matching line and sets its valid bit. No line is evicted and the round-robin pointer does not move.
- R5: Every write (req_write = 1) issues exactly one memory write and responds with rsp_hit = 0. If the reference matches a line, the field's data is replaced and its valid bit is set. If it does not match, no line is claimed.
- R6: A request with field index greater than or equal to FIELDS goes to memory and is never cached, so repeated reads of it always go to memory.
- R7: A one-cycle pulse on inval clears every field valid bit on the next edge. Line tags are kept. req_ready is 0 while inval is 1.
- R8: mem_req, once raised, holds with mem_ref, mem_fidx and mem_write unchanged until the cycle in which mem_ack is 1. It drops on the following edge.
- R9: Only one request is in flight at a time: req_ready is 0 from the edge that accepts a memory-bound request until the response edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| inval | input | 1 | Clear all field valid bits |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_ref | input | REF_W | Object reference |
| req_fidx | input | IDX_W | Field index |
| req_wdata | input | DATA_W | Write data |
| req_ready | output | 1 | Request accepted when high with req_valid |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_hit | output | 1 | Response served from the cache |
| rsp_rdata | output | DATA_W | Read data |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_write | output | 1 | Memory request is a write |
| mem_ref | output | REF_W | Memory object reference |
| mem_fidx | output | IDX_W | Memory field index |
| mem_wdata | output | DATA_W | Memory write data |
| mem_ack | input | 1 | Memory completes the request this cycle |
| mem_rdata | input | DATA_W | Memory read data, valid with mem_ack |

## Verification
The bench targets four cases:
- **Resident object, missing field.** A design that evicted instead of refilling in place would leave two lines holding the same reference. It would also lose an unrelated object that a later read expects to hit.
- **Round-robin eviction.** Objects are cycled through both lines so that a wrong victim choice turns an expected hit into a memory read.
- **Writes to absent objects, and out-of-range field indices.** A design that allocated on these would show a hit where a memory read is required, or data taken from the wrong field.
- **Invalidate.** Every field is cleared while the tags stay in place. A design that kept stale valid bits would return a hit right after the pulse.

// File: rtl/ofc_pkg.sv
// Shared definitions for the object field cache.
// Assumes nothing beyond standard SystemVerilog.
package ofc_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } ofc_state_e;

    // Width of an index over n entries, never below one bit.
    function automatic int ofc_idx_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/ofc_rr_victim.sv
// Round-robin line pointer: names the line claimed by the next allocation.
// Assumes LINES >= 2; the pointer moves only when adv is high.
module ofc_rr_victim
    import ofc_pkg::*;
#(
    parameter int LINES = 2,
    localparam int LW = ofc_idx_w(LINES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adv,
    output logic [LW-1:0] victim
);

    logic [LW-1:0] ptr_q;

    // Step the pointer on each allocation, wrapping at the last line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (adv) begin
            ptr_q <= (ptr_q == LW'(LINES - 1)) ? '0 : ptr_q + 1'b1;
        end
    end

    assign victim = ptr_q;

endmodule

// File: rtl/ofc_tag_store.sv
// Line tags (object references) with per-field valid bits.
// Compares every tag against the lookup reference in parallel, picks each
// line's valid bit with the field index, and encodes the matching line.
// Assumes at most one line holds a given reference (allocation on miss only).
module ofc_tag_store
    import ofc_pkg::*;
#(
    parameter int LINES  = 2,
    parameter int FIELDS = 4,
    parameter int REF_W  = 16,
    localparam int LW = ofc_idx_w(LINES),
    localparam int FW = ofc_idx_w(FIELDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inval,
    input  logic [REF_W-1:0] lk_ref,
    input  logic [FW-1:0]    lk_fidx,
    input  logic             alloc,
    input  logic [LW-1:0]    alloc_line,
    input  logic             set_v,
    input  logic [LW-1:0]    set_line,
    input  logic [FW-1:0]    set_fidx,
    output logic             tag_hit,
    output logic             field_hit,
    output logic [LW-1:0]    hit_line
);

    logic [LINES-1:0]        match;
    logic [LINES-1:0]        fhit;
    logic [LINES*FIELDS-1:0] vld_flat;

    for (genvar i = 0; i < LINES; i++) begin : g_line
        logic [REF_W-1:0]  tag_r;
        logic              used_r;
        logic [FIELDS-1:0] vld_r;

        // Hold this line's tag, its in-use flag and its field valid bits.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                tag_r  <= '0;
                used_r <= 1'b0;
                vld_r  <= '0;
            end else if (inval) begin
                vld_r <= '0;
            end else begin
                if (alloc && alloc_line == LW'(i)) begin
                    tag_r  <= lk_ref;
                    used_r <= 1'b1;
                    vld_r  <= '0;
                end
                if (set_v && set_line == LW'(i)) begin
                    vld_r[set_fidx] <= 1'b1;
                end
            end
        end

        assign match[i] = used_r && (tag_r == lk_ref);
        assign fhit[i]  = match[i] && vld_r[lk_fidx];
        assign vld_flat[i*FIELDS +: FIELDS] = vld_r;
    end

    // Encode the matching line number from the one-hot tag match.
    always_comb begin
        hit_line = '0;
        for (int i = 0; i < LINES; i++) begin
            if (match[i]) hit_line = hit_line | LW'(i);
        end
    end

    assign tag_hit   = |match;
    assign field_hit = |fhit;

    // R7
    inval_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inval |=> (vld_flat == '0));

    // R3
    one_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match));

endmodule

// File: rtl/ofc_data_ram.sv
// Field data store addressed by {line number, field index}.
// One synchronous write port, one combinational read port; no reset.
module ofc_data_ram
    import ofc_pkg::*;
#(
    parameter int LINES  = 2,
    parameter int FIELDS = 4,
    parameter int DATA_W = 32,
    localparam int LW    = ofc_idx_w(LINES),
    localparam int FW    = ofc_idx_w(FIELDS),
    localparam int AW    = LW + FW,
    localparam int DEPTH = 1 << AW
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [AW-1:0]     rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] mem_q [DEPTH];

    // Store one field per write strobe.
    always_ff @(posedge clk) begin
        if (wr_en) mem_q[wr_addr] <= wr_data;
    end

    assign rd_data = mem_q[rd_addr];

endmodule

// File: rtl/ofc_cache.sv
// Object field cache top: accepts one field read or write at a time,
// serves resident reads in one cycle, fetches single fields on a miss,
// writes through to memory, and bypasses out-of-range field indices.
// Assumes IDX_W is wide enough to encode indices at or beyond FIELDS.
module ofc_cache
    import ofc_pkg::*;
#(
    parameter int LINES  = 2,
    parameter int FIELDS = 4,
    parameter int REF_W  = 16,
    parameter int DATA_W = 32,
    parameter int IDX_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inval,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [REF_W-1:0]  req_ref,
    input  logic [IDX_W-1:0]  req_fidx,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              mem_req,
    output logic              mem_write,
    output logic [REF_W-1:0]  mem_ref,
    output logic [IDX_W-1:0]  mem_fidx,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata
);

    localparam int LW = ofc_idx_w(LINES);
    localparam int FW = ofc_idx_w(FIELDS);
    localparam logic [IDX_W:0] NFLD = (IDX_W + 1)'(FIELDS);

    ofc_state_e        state;
    logic              accept, in_range, rd_hit, alloc, wr_upd, fill_now;
    logic              tag_hit, field_hit;
    logic [LW-1:0]     hit_line, victim, set_line, fill_line;
    logic [FW-1:0]     fidx_lo, set_fidx, fill_fidx;
    logic              set_v, fill_pend;
    logic [DATA_W-1:0] ram_rd, ram_wd;

    assign req_ready = (state == ST_IDLE) && !inval;
    assign accept    = req_valid && req_ready;
    assign in_range  = ({1'b0, req_fidx} < NFLD);
    assign fidx_lo   = req_fidx[FW-1:0];
    assign rd_hit    = accept && !req_write && in_range && field_hit;
    assign alloc     = accept && !req_write && in_range && !tag_hit;
    assign wr_upd    = accept && req_write && in_range && tag_hit;
    assign fill_now  = (state == ST_WAIT) && mem_ack && fill_pend && !inval;
    assign set_v     = wr_upd || fill_now;
    assign set_line  = fill_now ? fill_line : hit_line;
    assign set_fidx  = fill_now ? fill_fidx : fidx_lo;
    assign ram_wd    = fill_now ? mem_rdata : req_wdata;

    ofc_tag_store #(.LINES(LINES), .FIELDS(FIELDS), .REF_W(REF_W)) u_tags (
        .clk        (clk),
        .rst_n      (rst_n),
        .inval      (inval),
        .lk_ref     (req_ref),
        .lk_fidx    (fidx_lo),
        .alloc      (alloc),
        .alloc_line (victim),
        .set_v      (set_v),
        .set_line   (set_line),
        .set_fidx   (set_fidx),
        .tag_hit    (tag_hit),
        .field_hit  (field_hit),
        .hit_line   (hit_line)
    );

    ofc_rr_victim #(.LINES(LINES)) u_victim (
        .clk    (clk),
        .rst_n  (rst_n),
        .adv    (alloc),
        .victim (victim)
    );

    ofc_data_ram #(.LINES(LINES), .FIELDS(FIELDS), .DATA_W(DATA_W)) u_data (
        .clk     (clk),
        .wr_en   (set_v),
        .wr_addr ({set_line, set_fidx}),
        .wr_data (ram_wd),
        .rd_addr ({hit_line, fidx_lo}),
        .rd_data (ram_rd)
    );

    // Sequence each request: local hit response, or one memory transaction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            mem_req   <= 1'b0;
            mem_write <= 1'b0;
            mem_ref   <= '0;
            mem_fidx  <= '0;
            mem_wdata <= '0;
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_rdata <= '0;
            fill_pend <= 1'b0;
            fill_line <= '0;
            fill_fidx <= '0;
        end else begin
            rsp_valid <= 1'b0;
            if (inval) fill_pend <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (accept) begin
                        if (rd_hit) begin
                            rsp_valid <= 1'b1;
                            rsp_hit   <= 1'b1;
                            rsp_rdata <= ram_rd;
                        end else begin
                            state     <= ST_WAIT;
                            mem_req   <= 1'b1;
                            mem_write <= req_write;
                            mem_ref   <= req_ref;
                            mem_fidx  <= req_fidx;
                            mem_wdata <= req_wdata;
                            fill_pend <= !req_write && in_range;
                            fill_line <= tag_hit ? hit_line : victim;
                            fill_fidx <= fidx_lo;
                        end
                    end
                end
                ST_WAIT: begin
                    if (mem_ack) begin
                        state     <= ST_IDLE;
                        mem_req   <= 1'b0;
                        rsp_valid <= 1'b1;
                        rsp_hit   <= 1'b0;
                        rsp_rdata <= mem_rdata;
                        fill_pend <= 1'b0;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R8
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_ref)
                                   && $stable(mem_fidx) && $stable(mem_write)));

    // R2
    hit_local_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_hit |=> (rsp_valid && rsp_hit && !mem_req));

    // R9
    busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !req_ready);

    // R6
    bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !in_range) |=> (mem_req && !rsp_valid));

    // R5
    write_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && req_write) |=> (mem_req && mem_write));

endmodule

// File: tb/ofc_cache_bench.sv
// Bench for ofc_cache: vector table walk, then directed reset/invalidate tests.
module ofc_cache_bench;

    localparam int REF_W  = 16;
    localparam int DATA_W = 32;
    localparam int IDX_W  = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              inval = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_write = 1'b0;
    logic [REF_W-1:0]  req_ref = '0;
    logic [IDX_W-1:0]  req_fidx = '0;
    logic [DATA_W-1:0] req_wdata = '0;
    logic              req_ready, rsp_valid, rsp_hit;
    logic [DATA_W-1:0] rsp_rdata;
    logic              mem_req, mem_write;
    logic [REF_W-1:0]  mem_ref;
    logic [IDX_W-1:0]  mem_fidx;
    logic [DATA_W-1:0] mem_wdata;
    logic              mem_ack = 1'b0;
    logic [DATA_W-1:0] mem_rdata;

    int checks = 0;
    int errors = 0;
    int mem_cnt = 0;

    always #5 clk = ~clk;

    ofc_cache u_ofc_cache (
        .clk(clk), .rst_n(rst_n), .inval(inval),
        .req_valid(req_valid), .req_write(req_write), .req_ref(req_ref),
        .req_fidx(req_fidx), .req_wdata(req_wdata), .req_ready(req_ready),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_rdata(rsp_rdata),
        .mem_req(mem_req), .mem_write(mem_write), .mem_ref(mem_ref),
        .mem_fidx(mem_fidx), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata)
    );

    // Backing memory model: 16 objects x 8 fields, one-cycle acknowledge.
    logic [DATA_W-1:0] mem_arr [128];
    initial begin
        for (int i = 0; i < 128; i++) mem_arr[i] = 32'hC0DE_0000 + 32'(i) * 32'h0101;
    end
    assign mem_rdata = mem_arr[{mem_ref[3:0], mem_fidx}];

    always @(posedge clk) begin
        mem_ack <= mem_req && !mem_ack;
        if (mem_req && mem_ack) begin
            mem_cnt <= mem_cnt + 1;
            if (mem_write) mem_arr[{mem_ref[3:0], mem_fidx}] <= mem_wdata;
        end
    end

    task automatic chk(input string rq, input bit ok, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    // Issue one request and wait for its response.
    task automatic run_req(input bit w, input logic [3:0] oref, input logic [2:0] fld,
                           input logic [DATA_W-1:0] wd, output logic [DATA_W-1:0] data,
                           output bit hit, output int lat, output int nmem, output bit rdy_busy);
        int m0;
        @(negedge clk);
        req_valid = 1'b1; req_write = w; req_ref = {12'h000, oref};
        req_fidx = fld; req_wdata = wd;
        m0 = mem_cnt;
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        rdy_busy = 1'b0;
        if (!rsp_valid) rdy_busy = !req_ready;
        while (!rsp_valid && lat < 50) begin
            @(negedge clk);
            lat++;
        end
        data = rsp_rdata;
        hit  = rsp_hit;
        nmem = mem_cnt - m0;
    endtask

    typedef struct packed {
        logic       wr;
        logic [3:0] oref;
        logic [2:0] fld;
        logic [7:0] wd;
        logic       ehit;
        logic [1:0] emem;
        logic [3:0] rq;
    } vec_t;

    // Two lines, round-robin from line 0; per-row requirement in rq.
    localparam vec_t VEC [20] = '{
        '{1'b0, 4'd1, 3'd0, 8'h00, 1'b0, 2'd1, 4'd3},  // R3 cold miss, line 0
        '{1'b0, 4'd1, 3'd0, 8'h00, 1'b1, 2'd0, 4'd2},  // R2 hit
        '{1'b0, 4'd1, 3'd1, 8'h00, 1'b0, 2'd1, 4'd4},  // R4 field refill in place
        '{1'b0, 4'd1, 3'd1, 8'h00, 1'b1, 2'd0, 4'd4},
        '{1'b0, 4'd2, 3'd0, 8'h00, 1'b0, 2'd1, 4'd3},  // R3 line 1
        '{1'b0, 4'd1, 3'd0, 8'h00, 1'b1, 2'd0, 4'd4},  // R4 ref1 not evicted
        '{1'b0, 4'd2, 3'd0, 8'h00, 1'b1, 2'd0, 4'd2},
        '{1'b0, 4'd3, 3'd2, 8'h00, 1'b0, 2'd1, 4'd3},  // R3 evicts ref1
        '{1'b0, 4'd1, 3'd0, 8'h00, 1'b0, 2'd1, 4'd3},  // R3 evicts ref2
        '{1'b0, 4'd3, 3'd2, 8'h00, 1'b1, 2'd0, 4'd3},
        '{1'b0, 4'd2, 3'd0, 8'h00, 1'b0, 2'd1, 4'd3},  // R3 evicts ref3
        '{1'b0, 4'd1, 3'd0, 8'h00, 1'b1, 2'd0, 4'd3},
        '{1'b1, 4'd1, 3'd3, 8'h3C, 1'b0, 2'd1, 4'd5},  // R5 write, resident
        '{1'b0, 4'd1, 3'd3, 8'h00, 1'b1, 2'd0, 4'd5},  // R5 written field hits
        '{1'b1, 4'd5, 3'd1, 8'h77, 1'b0, 2'd1, 4'd5},  // R5 write, absent
        '{1'b0, 4'd5, 3'd1, 8'h00, 1'b0, 2'd1, 4'd5},  // R5 no allocate on write
        '{1'b0, 4'd1, 3'd5, 8'h00, 1'b0, 2'd1, 4'd6},  // R6 bypass
        '{1'b0, 4'd1, 3'd5, 8'h00, 1'b0, 2'd1, 4'd6},  // R6 still bypass
        '{1'b0, 4'd2, 3'd0, 8'h00, 1'b1, 2'd0, 4'd3},
        '{1'b0, 4'd5, 3'd1, 8'h00, 1'b1, 2'd0, 4'd3}
    };

    task automatic do_vec(input vec_t v, input string rq);
        logic [DATA_W-1:0] data, exp_d, wd;
        bit hit, busy;
        int lat, nmem;
        wd = {24'h5A5A5A, v.wd};
        exp_d = mem_arr[{v.oref, v.fld}];
        run_req(v.wr, v.oref, v.fld, wd, data, hit, lat, nmem, busy);
        chk(rq, hit == v.ehit, hit, v.ehit);
        chk(rq, nmem == int'(v.emem), nmem, v.emem);
        if (!v.wr) chk(rq, data == exp_d, data, exp_d);
        if (v.ehit) chk({rq, " R2 latency"}, lat == 1, lat, 1);
        else begin
            chk({rq, " R3 latency"}, lat == 3, lat, 3);
            chk({rq, " R9 busy"}, busy, busy, 1);
        end
    endtask

    initial begin
        repeat (40000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [DATA_W-1:0] data;
        bit hit, busy;
        int lat, nmem;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        chk("R1 ready", req_ready == 1'b1, req_ready, 1);
        chk("R1 rsp", rsp_valid == 1'b0, rsp_valid, 0);
        chk("R1 mem", mem_req == 1'b0, mem_req, 0);
        rst_n = 1'b1;

        for (int i = 0; i < 20; i++) begin
            do_vec(VEC[i], $sformatf("R%0d vec%0d", VEC[i].rq, i));
        end

        // R5 overwrite of a valid field
        do_vec('{1'b1, 4'd2, 3'd0, 8'hEE, 1'b0, 2'd1, 4'd5}, "R5 overwrite");
        do_vec('{1'b0, 4'd2, 3'd0, 8'h00, 1'b1, 2'd0, 4'd5}, "R5 overwrite read");

        // R7 invalidate pulse
        @(negedge clk);
        inval = 1'b1;
        #1 chk("R7 ready low", req_ready == 1'b0, req_ready, 0);
        @(negedge clk);
        inval = 1'b0;
        do_vec('{1'b0, 4'd2, 3'd0, 8'h00, 1'b0, 2'd1, 4'd7}, "R7 cleared a");
        do_vec('{1'b0, 4'd5, 3'd1, 8'h00, 1'b0, 2'd1, 4'd7}, "R7 cleared b");
        do_vec('{1'b0, 4'd2, 3'd0, 8'h00, 1'b1, 2'd0, 4'd4}, "R4 refilled a");
        do_vec('{1'b0, 4'd5, 3'd1, 8'h00, 1'b1, 2'd0, 4'd4}, "R4 refilled b");

        // R1 reset again empties the cache
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 ready after reset", req_ready == 1'b1, req_ready, 1);
        rst_n = 1'b1;
        run_req(1'b0, 4'd2, 3'd0, '0, data, hit, lat, nmem, busy);
        chk("R1 empty after reset", nmem == 1 && !hit, nmem, 1);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule